// File: doc/BRIEF.md
# Sequential Fixed-Point Divider

This block divides one fixed-point operand by another, one quotient bit per clock. Each operand's format is fixed when the block is built: an integer-bit count and a fraction-bit count. A single parameter chooses whether both operands and the quotient are unsigned or two's complement. The quotient is wide enough that no non-zero divisor can overflow it. A few guard bits are produced below the quotient LSB and can feed a round-to-nearest step before the result is stored.

A caller presents both operands and pulses `start` while the block is idle. `busy` rises on the next cycle. When the quotient is ready, `busy` drops and `done` pulses for one cycle. The result then stays on `quotient` until the next result replaces it. A zero divisor skips the iteration: the block returns its largest positive code and raises `div_by_zero` in the same cycle as `done`.

In this text WA = A_INT+A_FRAC, WB = B_INT+B_FRAC, WQ = WA+WB and G = GUARD.

Top module: `fxd_div`

## Requirements
- R1: The quotient is WQ bits wide and equals dividend/divisor scaled by 2^QF. QF = A_FRAC+B_INT-1 in signed mode and A_FRAC+B_INT in unsigned mode.
- R2: In signed mode both operands are two's complement. The block divides the magnitudes and negates the result when the operand signs differ, so rounding is symmetric about zero.
- R3: For any non-zero divisor the quotient never overflows. This includes the most negative dividend divided by the smallest divisor magnitude, and the largest unsigned dividend divided by one LSB.
- R4: With rounding on and G > 0 (default G = 3), G extra bits are computed below the quotient LSB. The magnitude is incremented when the first extra bit is 1 and either the kept LSB is 1, or a lower extra bit is 1, or the final remainder is non-zero.
- R5: With G = 0, or with ROUND_EN = 0, the magnitude is truncated, which rounds toward zero.
- R6: A start with a zero divisor gives `done` and `div_by_zero` high together on the next cycle, with `busy` never raised. The quotient is then the most positive code: 0x7FFF for a signed 16-bit quotient, 0xFFFF for an unsigned one.
- R7: For a non-zero divisor, `done` is high exactly NB+1 cycles after the start cycle. NB = WA+WB-1+G in signed mode and WA+WB+G in unsigned mode.
- R8: `busy` is high from the cycle after an accepted start up to the cycle before `done`. `done` lasts one cycle and is never high together with `busy`.
- R9: A `start` seen while `busy` is high is ignored. The result of the division already running is unchanged.
- R10: After reset, `busy`, `done`, `div_by_zero` and `quotient` are zero. `quotient` changes only in a cycle where `done` is high, and `div_by_zero` is low except in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a division when the block is idle |
| dividend | input | WA | Dividend, A_FRAC fraction bits |
| divisor | input | WB | Divisor, B_FRAC fraction bits |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: result valid |
| div_by_zero | output | 1 | Divisor was zero, high together with done |
| quotient | output | WQ | Result, QF fraction bits |

## Verification
The hardest case to reach is the rounding corner in which the first guard bit is 1, the lower guard bits are all 0, and only the final remainder decides whether the result rounds up. It happens only for some divisor and dividend pairs. A long stream of random operand pairs reaches it, and every result is compared against exact integer division done in the bench. A second instance, unsigned with no guard bits, receives the same stimulus. It covers truncation and the different latency, and a start pulse issued partway through a division checks that late starts are ignored in both formats.

// File: rtl/fxd_div_pkg.sv
package fxd_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // Left shift applied to the dividend magnitude so that the integer
  // quotient carries QF fraction bits plus the guard bits.
  function automatic int num_shift(input bit sgn, input int wb, input int g);
    return sgn ? (wb - 1 + g) : (wb + g);
  endfunction

  // Round to nearest, ties to an even kept LSB.
  function automatic logic round_decide(input logic lsb, input logic first,
                                        input logic rest);
    return first & (lsb | rest);
  endfunction

endpackage

// File: rtl/fxd_div_prep.sv
module fxd_div_prep #(
  parameter int WA  = 8,
  parameter int WB  = 8,
  parameter bit SGN = 1'b1
) (
  input  logic [WA-1:0] a_raw,
  input  logic [WB-1:0] b_raw,
  output logic [WA-1:0] a_mag,
  output logic [WB-1:0] b_mag,
  output logic          neg,
  output logic          b_zero
);
  assign b_zero = (b_raw == '0);

  generate
    if (SGN) begin : g_signed
      // Negating the most negative code yields 2^(W-1), which still fits
      // as an unsigned magnitude of width W.
      assign a_mag = a_raw[WA-1] ? (~a_raw + WA'(1)) : a_raw;
      assign b_mag = b_raw[WB-1] ? (~b_raw + WB'(1)) : b_raw;
      assign neg   = a_raw[WA-1] ^ b_raw[WB-1];
    end else begin : g_unsigned
      assign a_mag = a_raw;
      assign b_mag = b_raw;
      assign neg   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fxd_div_core.sv
module fxd_div_core #(
  parameter int WA = 8,
  parameter int WB = 8,
  parameter int SH = 10,
  parameter int NB = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WA-1:0] a_mag,
  input  logic [WB-1:0] b_mag,
  output logic          step,
  output logic          last,
  output logic [NB-1:0] quo,
  output logic          rem_nz
);
  localparam int CW = $clog2(NB + 1);

  logic [NB-1:0] num_sr;
  logic [NB-1:0] quo_sr;
  logic [WB-1:0] rem_r;
  logic [WB-1:0] den_r;
  logic [CW-1:0] cnt;
  logic          act;

  logic [WB:0]   trial;
  logic [WB:0]   diff;
  logic          fits;

  // Restoring step: bring down the next dividend bit, subtract if it fits.
  assign trial = {rem_r, num_sr[NB-1]};
  assign fits  = (trial >= {1'b0, den_r});
  assign diff  = trial - {1'b0, den_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_sr <= '0;
      quo_sr <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt    <= '0;
      act    <= 1'b0;
    end else if (load) begin
      num_sr <= NB'(a_mag) << SH;
      quo_sr <= '0;
      rem_r  <= '0;
      den_r  <= b_mag;
      cnt    <= CW'(NB);
      act    <= 1'b1;
    end else if (act) begin
      num_sr <= {num_sr[NB-2:0], 1'b0};
      quo_sr <= {quo_sr[NB-2:0], fits};
      rem_r  <= fits ? diff[WB-1:0] : trial[WB-1:0];
      cnt    <= cnt - CW'(1);
      if (cnt == CW'(1)) act <= 1'b0;
    end
  end

  assign step   = act;
  assign last   = act && (cnt == CW'(1));
  assign quo    = quo_sr;
  assign rem_nz = |rem_r;
endmodule

// File: rtl/fxd_div_round.sv
module fxd_div_round #(
  parameter int NB  = 18,
  parameter int G   = 3,
  parameter int WQ  = 16,
  parameter bit RND = 1'b1
) (
  input  logic [NB-1:0] raw,
  input  logic          rem_nz,
  input  logic          neg,
  output logic [WQ-1:0] q
);
  import fxd_div_pkg::*;

  localparam int BW = NB - G;

  logic [BW-1:0] base;
  logic          inc;
  logic [WQ-1:0] mag;

  assign base = raw[NB-1:G];

  generate
    if (RND && (G > 0)) begin : g_round
      logic [G-1:0] grd;
      logic         rest;
      assign grd  = raw[G-1:0];
      // Shifting left inside G bits drops the first guard bit.
      assign rest = (|G'(grd << 1)) | rem_nz;
      assign inc  = round_decide(base[0], grd[G-1], rest);
    end else begin : g_trunc
      logic unused_rnd;
      assign unused_rnd = rem_nz ^ (^raw);
      assign inc        = 1'b0;
    end
  endgenerate

  assign mag = WQ'(base) + WQ'(inc);
  assign q   = neg ? (~mag + WQ'(1)) : mag;
endmodule

// File: rtl/fxd_div.sv
module fxd_div #(
  parameter int A_INT       = 4,
  parameter int A_FRAC      = 4,
  parameter int B_INT       = 4,
  parameter int B_FRAC      = 4,
  parameter bit SIGNED_MODE = 1'b1,
  parameter int GUARD       = 3,
  parameter bit ROUND_EN    = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [A_INT+A_FRAC-1:0]               dividend,
  input  logic [B_INT+B_FRAC-1:0]               divisor,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  div_by_zero,
  output logic [A_INT+A_FRAC+B_INT+B_FRAC-1:0]  quotient
);
  import fxd_div_pkg::*;

  localparam int WA = A_INT + A_FRAC;
  localparam int WB = B_INT + B_FRAC;
  localparam int WQ = WA + WB;
  localparam int SH = num_shift(SIGNED_MODE, WB, GUARD);
  localparam int NB = WA + SH;
  localparam logic [WQ-1:0] MAXPOS =
    SIGNED_MODE ? {1'b0, {(WQ-1){1'b1}}} : {WQ{1'b1}};

  logic [WA-1:0] a_mag;
  logic [WB-1:0] b_mag;
  logic          op_neg;
  logic          b_zero;
  logic          core_load;
  logic          core_step;
  logic          core_last;
  logic [NB-1:0] core_quo;
  logic          core_rem_nz;
  logic [WQ-1:0] rnd_q;

  div_state_e    state;
  logic          neg_q;
  logic          busy_q;
  logic          done_q;
  logic          dbz_q;
  logic [WQ-1:0] quo_q;

  fxd_div_prep #(.WA(WA), .WB(WB), .SGN(SIGNED_MODE)) u_prep (
    .a_raw  (dividend),
    .b_raw  (divisor),
    .a_mag  (a_mag),
    .b_mag  (b_mag),
    .neg    (op_neg),
    .b_zero (b_zero)
  );

  assign core_load = (state == ST_IDLE) && start && !b_zero;

  fxd_div_core #(.WA(WA), .WB(WB), .SH(SH), .NB(NB)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (core_load),
    .a_mag  (a_mag),
    .b_mag  (b_mag),
    .step   (core_step),
    .last   (core_last),
    .quo    (core_quo),
    .rem_nz (core_rem_nz)
  );

  fxd_div_round #(.NB(NB), .G(GUARD), .WQ(WQ), .RND(ROUND_EN)) u_round (
    .raw    (core_quo),
    .rem_nz (core_rem_nz),
    .neg    (neg_q),
    .q      (rnd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (b_zero) begin
              quo_q  <= MAXPOS;
              done_q <= 1'b1;
              dbz_q  <= 1'b1;
            end else begin
              neg_q  <= op_neg;
              busy_q <= 1'b1;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (core_last) state <= ST_FIN;
        end
        ST_FIN: begin
          quo_q  <= rnd_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign div_by_zero = dbz_q;
  assign quotient    = quo_q;
endmodule

// File: rtl/fxd_div_checker.sv
module fxd_div_checker #(
  parameter int NB  = 18,
  parameter int WQ  = 16,
  parameter bit SGN = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          b_zero,
  input logic          busy,
  input logic          done,
  input logic          div_by_zero,
  input logic [WQ-1:0] quotient,
  input logic          core_step,
  input logic          neg_q
);
  localparam logic [WQ-1:0] MAXPOS =
    SGN ? {1'b0, {(WQ-1){1'b1}}} : {WQ{1'b1}};
  localparam int LW = $clog2(NB + 3);

  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_cnt <= '0;
    else if (!busy) lat_cnt <= '0;
    else            lat_cnt <= lat_cnt + LW'(1);
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && !b_zero) |=> busy);

  assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && b_zero) |=> (done && div_by_zero && !busy));

  assert_zero_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (quotient == MAXPOS));

  assert_flag_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quotient) |-> done);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (lat_cnt == LW'(NB + 1)));

  assert_step_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |-> busy);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (SGN && done && !div_by_zero && !neg_q) |-> !quotient[WQ-1]);
endmodule

bind fxd_div fxd_div_checker #(.NB(NB), .WQ(WQ), .SGN(SIGNED_MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .b_zero      (b_zero),
  .busy        (busy),
  .done        (done),
  .div_by_zero (div_by_zero),
  .quotient    (quotient),
  .core_step   (core_step),
  .neg_q       (neg_q)
);

// File: tb/fxd_div_bench.sv
`timescale 1ns/1ps
module fxd_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  a_in = '0;
  logic [7:0]  b_in = '0;

  logic        busy0, done0, dbz0, busy1, done1, dbz1;
  logic [15:0] q0, q1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_tag = "R10";

  bit     m_busy [2];
  bit     m_done [2];
  bit     m_dbz  [2];
  int     m_cnt  [2];
  longint m_q    [2];
  longint m_pend [2];

  always #2 clk = ~clk;

  // Instance 0: signed 4.4 / 4.4, three guard bits, rounding on.
  fxd_div u_fxd_div (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(a_in), .divisor(b_in),
    .busy(busy0), .done(done0), .div_by_zero(dbz0), .quotient(q0));

  // Instance 1: unsigned, no guard bits, so rounding is off (R5).
  fxd_div #(.SIGNED_MODE(1'b0), .GUARD(0)) u_fxd_div_uns (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(a_in), .divisor(b_in),
    .busy(busy1), .done(done1), .div_by_zero(dbz1), .quotient(q1));

  function automatic longint ref_q(logic [7:0] a, logic [7:0] b, bit sgn, int g);
    longint av, bv, am, bm, n, qi, r, base, grd;
    bit neg, half, low;
    int sh;
    av = sgn ? longint'($signed(a)) : longint'(a);
    bv = sgn ? longint'($signed(b)) : longint'(b);
    am = (av < 0) ? -av : av;
    bm = (bv < 0) ? -bv : bv;
    neg = (av < 0) != (bv < 0);
    sh = sgn ? 7 + g : 8 + g;
    n = am << sh;
    qi = n / bm;
    r = n % bm;
    base = qi >> g;
    if (g > 0) begin
      grd  = qi & ((64'sd1 << g) - 1);
      half = ((grd >> (g - 1)) & 1) != 0;
      low  = ((grd & ((64'sd1 << (g - 1)) - 1)) != 0) || (r != 0);
      if (half && (base[0] || low)) base = base + 1;
    end
    if (neg) base = -base;
    return base & 64'hFFFF;
  endfunction

  // Cycle-accurate reference model.
  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_busy[k] <= 1'b0; m_done[k] <= 1'b0; m_dbz[k] <= 1'b0;
        m_cnt[k] <= 0; m_q[k] <= 0; m_pend[k] <= 0;
      end else begin
        m_done[k] <= 1'b0;
        m_dbz[k]  <= 1'b0;
        if (m_busy[k]) begin
          if (m_cnt[k] == 1) begin
            m_busy[k] <= 1'b0; m_done[k] <= 1'b1; m_q[k] <= m_pend[k];
          end else m_cnt[k] <= m_cnt[k] - 1;
        end else if (start) begin
          if (b_in == 8'h00) begin
            m_done[k] <= 1'b1; m_dbz[k] <= 1'b1;
            m_q[k] <= (k == 0) ? 64'h7FFF : 64'hFFFF;
          end else begin
            m_busy[k] <= 1'b1;
            m_cnt[k]  <= (k == 0) ? 19 : 17;
            m_pend[k] <= ref_q(a_in, b_in, k == 0, (k == 0) ? 3 : 0);
          end
        end
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8", "busy0", longint'(busy0), longint'(m_busy[0]));
      chk("R7", "done0", longint'(done0), longint'(m_done[0]));
      chk("R6", "dbz0",  longint'(dbz0),  longint'(m_dbz[0]));
      chk(cur_tag, "quotient0", longint'(q0), m_q[0]);
      chk("R8", "busy1", longint'(busy1), longint'(m_busy[1]));
      chk("R7", "done1", longint'(done1), longint'(m_done[1]));
      chk("R6", "dbz1",  longint'(dbz1),  longint'(m_dbz[1]));
      chk("R5", "quotient1", longint'(q1), m_q[1]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_idle();
    while (m_busy[0] || m_busy[1] || m_done[0] || m_done[1]) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset busy", longint'(busy0 | busy1), 0);
    chk("R10", "reset done", longint'(done0 | done1), 0);
    chk("R10", "reset flag", longint'(dbz0 | dbz1), 0);
    chk("R10", "reset quotient", longint'(q0 | q1), 0);
    rst_n = 1'b1;

    cur_tag = "R1";
    op(8'h68, 8'h20);            // 6.5 / 2 = 3.25 -> 0x01A0
    chk("R1", "6.5/2", longint'(q0), 64'h01A0);
    op(8'h10, 8'h30);            // 1 / 3
    op(8'h08, 8'h01);

    cur_tag = "R2";
    op(8'hCC, 8'h18);            // -3.25 / 1.5
    op(8'h68, 8'hE0);            // 6.5 / -2 = -3.25 -> 0xFE60
    chk("R2", "6.5/-2", longint'(q0), 64'hFE60);
    op(8'h98, 8'hE0);            // -6.5 / -2
    op(8'hF0, 8'h30);            // -1 / 3

    cur_tag = "R3";
    op(8'h80, 8'h01);            // -8 / (1/16) = -128 -> 0xC000
    chk("R3", "most negative / lsb", longint'(q0), 64'hC000);
    op(8'h7F, 8'h01);
    op(8'h80, 8'hFF);            // -8 / -(1/16) = +128
    op(8'hFF, 8'h01);
    chk("R3", "unsigned max / lsb", longint'(q1), 64'hFF00);
    op(8'h01, 8'h7F);

    cur_tag = "R6";
    op(8'h55, 8'h00);
    chk("R6", "zero divisor signed", longint'(q0), 64'h7FFF);
    chk("R6", "zero divisor unsigned", longint'(q1), 64'hFFFF);
    op(8'h00, 8'h00);

    cur_tag = "R9";
    @(negedge clk);
    a_in = 8'h30; b_in = 8'h50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    a_in = 8'h11; b_in = 8'h00; start = 1'b1;   // ignored while busy
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R9", "late start ignored", longint'(q0), ref_q(8'h30, 8'h50, 1'b1, 3));

    cur_tag = "R10";
    a_in = 8'h7E; b_in = 8'h03;
    repeat (12) @(negedge clk);

    cur_tag = "R4";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra;
      logic [7:0] rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (i % 50 == 7) rb = 8'h00;
      op(ra, rb);
    end

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule